// File: doc/BRIEF.md
# Ethernet PHY Clock Generator

This block produces the PHY reference clock and the transmit clock for an Ethernet MAC. A single 32-bit configuration register controls it. The register is written over a plain port with a write enable and write data, and it reads back at all times. Two fast source clocks reach the block as single-cycle strobes in the core clock domain: `src_tick0_i` and `src_tick1_i`. A select bit picks one strobe stream. A one-based integer divider counts the selected strobes. A second stage then divides the result by a slow or a fast ratio (5 or 10 by default). The output of that second stage is the reference clock.

The register also holds the settings the MAC side needs. These are the interface mode (RGMII or RMII), a 2-bit transmit-delay code that leaves the block on a port, and a bit that inverts the transmit clock in RMII mode. A master enable gates both clock outputs. A new divider or source setting does not cut a pulse short. Each stage picks up its new setting only at its own terminal count.

Top module: `eth_phy_clkgen`

## Requirements
- R1: After reset the register reads 0, and `ref_clk_o`, `tx_clk_o`, `rgmii_sel_o` and `tx_delay_o` are all low.
- R2: The implemented fields are: bit 0 mode, bit 4 source, bits 6:5 delay, bits 9:7 divide code, bit 10 second-stage ratio, bit 11 inversion and bit 12 enable. Read-back returns these fields. All other bits read as 0, whatever was written to them.
- R3: Bit 0 set selects RGMII and bit 0 clear selects RMII. `rgmii_sel_o` follows bit 0. A write with bit 0 set stores bits 6:5 and drives them on `tx_delay_o`. A write with bit 0 clear stores 0 in that field.
- R4: Bit 4 clear clocks the divider from `src_tick0_i`. Bit 4 set clocks it from `src_tick1_i`.
- R5: Bits 9:7 hold a one-based divide code N. The first stage emits one event every N selected strobes. Code 0 acts as divide-by-one.
- R6: Bit 10 clear divides the first-stage events by 5, and bit 10 set divides them by 10. The ref clock period is therefore N·M source strobes. It is high for floor(M/2) first-stage periods.
- R7: Bit 11 is stored only on a write with bit 0 clear. While it is set and the outputs are enabled, `tx_clk_o` is the inverse of `ref_clk_o`. Otherwise `tx_clk_o` equals `ref_clk_o`.
- R8: Bit 12 enables both clock outputs. From the cycle after a write that clears it, both outputs stay low.
- R9: A changed source, divide code or ratio takes effect only at the terminal count of the stage it belongs to. No high or low run of `ref_clk_o` is shorter than the shorter of the old and new runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read-back |
| src_tick0_i | input | 1 | Strobe of source clock 0 |
| src_tick1_i | input | 1 | Strobe of source clock 1 |
| ref_clk_o | output | 1 | PHY reference clock |
| tx_clk_o | output | 1 | Transmit clock, inverted in RMII when selected |
| rgmii_sel_o | output | 1 | 1 = RGMII, 0 = RMII |
| tx_delay_o | output | 2 | Transmit-delay code (0, 1/4, 1/2, 3/4 cycle) |

## Verification
A register write and a terminal count of either divider stage can land in the same cycle. The stage then has to take either the old setting or the new one for a whole period, never a mix. The bench provokes this by writing a new divide code and ratio at a varying number of cycles after a rising edge of the reference clock. While the change passes through both stages, it records every high and low run. It judges the runs against the shorter bound of the two settings. It then checks that the steady period and high time match the new setting.

// File: rtl/eth_phy_clkgen.sv
module eth_phy_clkgen #(
  parameter int REG_W    = 32,
  parameter int DIV1_W   = 3,
  parameter int SLOW_DIV = 5,
  parameter int FAST_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             src_tick0_i,
  input  logic             src_tick1_i,
  output logic             ref_clk_o,
  output logic             tx_clk_o,
  output logic             rgmii_sel_o,
  output logic [1:0]       tx_delay_o
);
  localparam int C1W   = DIV1_W + 1;
  localparam int C2W   = $clog2(FAST_DIV + 1);
  localparam int B_MOD = 0;
  localparam int B_SEL = 4;
  localparam int B_DLY = 5;
  localparam int B_DIV = 7;
  localparam int B_M25 = B_DIV + DIV1_W;
  localparam int B_INV = B_M25 + 1;
  localparam int B_EN  = B_INV + 1;

  logic              mode_q, sel_q, m25_q, inv_q, en_q;
  logic [1:0]        dly_q;
  logic [DIV1_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0; sel_q <= 1'b0; m25_q <= 1'b0;
      inv_q  <= 1'b0; en_q  <= 1'b0; dly_q <= '0; div_q <= '0;
    end else if (cfg_we) begin
      mode_q <= cfg_wdata[B_MOD];
      sel_q  <= cfg_wdata[B_SEL];
      dly_q  <= cfg_wdata[B_MOD] ? cfg_wdata[B_DLY+1:B_DLY] : 2'b00;
      div_q  <= cfg_wdata[B_DIV+DIV1_W-1:B_DIV];
      m25_q  <= cfg_wdata[B_M25];
      inv_q  <= cfg_wdata[B_INV] & ~cfg_wdata[B_MOD];
      en_q   <= cfg_wdata[B_EN];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[B_MOD]                  = mode_q;
    cfg_rdata[B_SEL]                  = sel_q;
    cfg_rdata[B_DLY+1:B_DLY]          = dly_q;
    cfg_rdata[B_DIV+DIV1_W-1:B_DIV]   = div_q;
    cfg_rdata[B_M25]                  = m25_q;
    cfg_rdata[B_INV]                  = inv_q;
    cfg_rdata[B_EN]                   = en_q;
  end

  function automatic logic [C1W-1:0] ratio1(input logic [DIV1_W-1:0] code);
    return (code == '0) ? C1W'(1) : C1W'(code);
  endfunction

  function automatic logic [C2W-1:0] ratio2(input logic fast);
    return fast ? C2W'(FAST_DIV) : C2W'(SLOW_DIV);
  endfunction

  // first stage: source mux and one-based divider
  logic           sel_a;
  logic [C1W-1:0] c1, r1_a;
  logic           tick, t1_end;

  assign tick   = sel_a ? src_tick1_i : src_tick0_i;
  assign t1_end = tick && (c1 == r1_a - C1W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1 <= '0; r1_a <= C1W'(1); sel_a <= 1'b0;
    end else if (tick) begin
      if (t1_end) begin
        c1    <= '0;
        r1_a  <= ratio1(div_q);
        sel_a <= sel_q;
      end else begin
        c1 <= c1 + C1W'(1);
      end
    end
  end

  // second stage: 5/10 divider producing the output level
  logic [C2W-1:0] c2, r2_a, r2_n;
  logic           t2_end, lvl2;

  assign r2_n   = ratio2(m25_q);
  assign t2_end = t1_end && (c2 == r2_a - C2W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c2 <= '0; r2_a <= C2W'(SLOW_DIV); lvl2 <= 1'b0;
    end else if (t1_end) begin
      if (t2_end) begin
        c2   <= '0;
        r2_a <= r2_n;
        lvl2 <= (r2_n >> 1) != '0;
      end else begin
        c2   <= c2 + C2W'(1);
        lvl2 <= (c2 + C2W'(1)) < (r2_a >> 1);
      end
    end
  end

  assign ref_clk_o   = en_q & lvl2;
  assign tx_clk_o    = en_q & (lvl2 ^ (inv_q & ~mode_q));
  assign rgmii_sel_o = mode_q;
  assign tx_delay_o  = dly_q;

  AST_RMII_DLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[B_MOD]) |=> (tx_delay_o == 2'b00)); // R3
  AST_SRC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_end |=> $stable(sel_a)); // R4
  AST_DIV1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (c1 < r1_a) && (r1_a != '0)); // R5
  AST_DIV2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    c2 < r2_a); // R6
  AST_RGMII_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[B_MOD]) |=> (tx_clk_o == ref_clk_o)); // R7
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[B_EN]) |=> (!ref_clk_o && !tx_clk_o)); // R8
  AST_LEVEL_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_end |=> $stable(lvl2)); // R9
  AST_RATIO_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !t2_end |=> $stable(r2_a)); // R9
endmodule

// File: tb/tb_eth_phy_clkgen.sv
module tb_eth_phy_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        src_tick0_i = 1'b0, src_tick1_i = 1'b0;
  logic        ref_clk_o, tx_clk_o, rgmii_sel_o;
  logic [1:0]  tx_delay_o;

  int checks = 0, fails = 0;
  bit done = 0;

  eth_phy_clkgen dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_tick0_i(src_tick0_i), .src_tick1_i(src_tick1_i),
    .ref_clk_o(ref_clk_o), .tx_clk_o(tx_clk_o), .rgmii_sel_o(rgmii_sel_o),
    .tx_delay_o(tx_delay_o));

  always #4 clk = ~clk;

  // source 0 strobes every cycle, source 1 every third cycle
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      src_tick0_i = 1'b1;
      src_tick1_i = (ph == 0);
      ph = (ph == 2) ? 0 : ph + 1;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  function automatic logic [31:0] exp_rb(input logic [31:0] w);
    logic [31:0] r = '0;
    r[0] = w[0]; r[4] = w[4];
    r[6:5] = w[0] ? w[6:5] : 2'b00;
    r[9:7] = w[9:7]; r[10] = w[10];
    r[11] = w[0] ? 1'b0 : w[11];
    r[12] = w[12];
    return r;
  endfunction

  function automatic int exp_period(input logic [31:0] w);
    int n = (w[9:7] == 0) ? 1 : int'(w[9:7]);
    int m = w[10] ? 10 : 5;
    int p = w[4] ? 3 : 1;
    return n * m * p;
  endfunction

  function automatic int exp_high(input logic [31:0] w);
    int n = (w[9:7] == 0) ? 1 : int'(w[9:7]);
    int m = w[10] ? 10 : 5;
    int p = w[4] ? 3 : 1;
    return (m / 2) * n * p;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // finds a rising edge, then measures high time and full period
  task automatic measure(output int per, output int hi);
    logic prev;
    int n;
    per = -1; hi = -1;
    prev = ref_clk_o; n = 0;
    while (!(ref_clk_o && !prev) && n < 2000) begin
      prev = ref_clk_o; @(negedge clk); n++;
    end
    if (n >= 2000) return;
    hi = 0; per = 0;
    while (ref_clk_o && per < 2000) begin @(negedge clk); hi++; per++; end
    while (!ref_clk_o && per < 2000) begin @(negedge clk); per++; end
  endtask

  task automatic check_tx(input string tag, input logic inv, input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tx_clk_o != (inv ? !ref_clk_o : ref_clk_o)) bad++;
    end
    check(tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int per, hi;
    logic [31:0] w;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", int'(cfg_rdata), 0);
    check("R1 outputs", int'({ref_clk_o, tx_clk_o, rgmii_sel_o, tx_delay_o}), 0);

    wr(32'hFFFF_FFFF);
    check("R2 readback rgmii", int'(cfg_rdata), 32'h17F1);
    check("R3 delay rgmii", int'(tx_delay_o), 3);
    check("R3 mode pin", int'(rgmii_sel_o), 1);
    wr(32'hFFFF_FFFE);
    check("R2 readback rmii", int'(cfg_rdata), 32'h1F90);
    check("R3 delay rmii", int'(tx_delay_o), 0);

    w = 32'h1000;
    wr(w);
    repeat (20) @(negedge clk);
    measure(per, hi);
    check("R5 code0 period", per, 5);
    check("R6 code0 high", hi, 2);

    w = 32'h1000 | (32'd4 << 7) | (32'd1 << 10) | 32'h11;
    wr(w);
    repeat (300) @(negedge clk);
    measure(per, hi);
    check("R4 src1 period", per, exp_period(w));
    check("R6 div10 high", hi, exp_high(w));

    w = 32'h1800 | (32'd3 << 7);
    wr(w);
    repeat (40) @(negedge clk);
    check_tx("R7 rmii inverted", 1'b1, 40);

    wr(w & ~32'h1000);
    begin
      int bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (ref_clk_o || tx_clk_o) bad++;
      end
      check("R8 gated low", bad, 0);
    end

    for (int it = 0; it < 16; it++) begin
      w = $urandom;
      w[12] = 1'b1;
      wr(w);
      check("R2 random readback", int'(cfg_rdata), int'(exp_rb(w)));
      check("R3 random delay", int'(tx_delay_o), w[0] ? int'(w[6:5]) : 0);
      measure(per, hi);
      measure(per, hi);
      measure(per, hi);
      check("R6 random period", per, exp_period(w));
      check("R6 random high", hi, exp_high(w));
      check_tx("R7 random tx", w[11] & ~w[0], 30);
    end

    // write lands at varying offsets against terminal counts
    for (int k = 0; k < 6; k++) begin
      logic [31:0] wa, wb;
      int hmin = 1000, lmin = 1000, run = 0, seen = 0;
      logic prev;
      wa = 32'h1000 | (32'd6 << 7) | (32'd1 << 10);
      wb = 32'h1000 | (32'd2 << 7);
      wr(wa);
      repeat (150) @(negedge clk);
      measure(per, hi);
      repeat (k * 7 + ($urandom % 5)) @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = wb;
      @(negedge clk);
      cfg_we = 1'b0;
      prev = ref_clk_o;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (ref_clk_o != prev) begin
          if (seen > 0) begin
            if (prev) hmin = (run < hmin) ? run : hmin;
            else      lmin = (run < lmin) ? run : lmin;
          end
          seen++; run = 1;
        end else run++;
        prev = ref_clk_o;
      end
      check("R9 no short high", int'(hmin >= 4), 1);
      check("R9 no short low", int'(lmin >= 6), 1);
      measure(per, hi);
      check("R9 new period", per, exp_period(wb));
      check("R9 new high", hi, exp_high(wb));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule